// File: doc/BRIEF.md
# Imager front-end initialization sequencer

This block is the host-side controller that takes an imaging timing-generator device from power-on to active clock output. When `start` arrives in the idle state, it plays a fixed list of register writes to the device over a 3-wire serial link. The link has a serial clock, a data line and an active-low load strobe. The list comes from a small internal table of address/data pairs whose contents are computed at elaboration. The vertical and horizontal sync enables stay low for as long as any write is in flight. No half-written register set can therefore be committed.

The order of the writes is fixed by the device:
1. A soft reset, whose bit clears itself on the device and is never written back.
2. The user timing registers.
3. The exit from standby.
4. A start of the timing core.
5. Last, the output-control bit.

The output-control setting only takes effect at a later sync edge. The sequencer therefore raises both sync enables after the final write and waits for a falling edge on the observed VD line. It then asserts `done`.

The controller is a six-state machine with these states and transitions:
- `S_IDLE` moves to `S_ISSUE` on `start`.
- `S_ISSUE` launches one frame and moves to `S_SHIFT`.
- `S_SHIFT` moves to `S_ADVANCE` when the frame ends.
- `S_ADVANCE` either moves back to `S_ISSUE` with the next table index, or moves to `S_WAIT_VD` after the last entry.
- `S_WAIT_VD` moves to `S_DONE` on a VD falling edge.
- `S_DONE` moves to `S_ISSUE` on a new `start`, beginning again at index 0.
- A synchronous `rst` sends every state to `S_IDLE`.

Top module: `imgfe_init_seq`

## Requirements
- R1: One clock edge after `rst` is sampled high, the outputs are idle: `ser_load_n`=1, `ser_clk`=0, `ser_data`=0, `vd_en`=0, `hd_en`=0 and `done`=0. This holds whether the block was idle, writing or done.
- R2: A `start` sampled in the idle state runs exactly N_USER+4 serial frames. N_USER is 4 by default, giving 8 frames.
- R3: Frame format:
  - `ser_load_n` is low for the whole frame, and `ser_clk` rises only while it is low.
  - Each frame has exactly 30 rising edges of `ser_clk`, with `ser_data` stable while `ser_clk` is high.
  - The bits are the 6-bit address, LSB first, then the 24-bit data, LSB first. Each bit is taken at a rising edge.
  - `ser_clk` idles low, and each of its low and high phases lasts SCLK_HALF clocks (default 2).
- R4: The first frame writes data 1 to address 0x10 (soft reset). No later frame of the sequence addresses 0x10.
- R5: Frames 2 to N_USER+1 write the user entries in ascending order i = 0..N_USER-1. Entry i goes to address USER_BASE+i, with USER_BASE = 0x20 by default. Its data bytes, from most to least significant, are (0xA0+i) mod 256, 0x3C xor i, and (17*i+1) mod 256.
- R6: The next frame writes data 0 to address 0x00, which leaves standby and powers up the reference buffer.
- R7: The next frame writes data 1 to address 0x14, which starts the timing core.
- R8: The last frame writes data 1 to address 0x11, the output-control bit.
- R9: `vd_en` and `hd_en` are 0 during every frame and between frames. Both go to 1 after the last frame ends.
- R10: With the enables high, `done` goes to 1 after the first clock edge at which `vd_in` is sampled low, provided it was sampled high at the edge before.
  - VD falling edges seen before the enables rise are ignored.
  - If `vd_in` is already low when the enables rise, it must first go high and then fall before `done` is set.
- R11: A `start` sampled while frames are being written is ignored: the sequence neither restarts nor changes.
- R12: A `start` sampled in the done state clears `done`, `vd_en` and `hd_en` at that edge and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to run the initialization sequence |
| vd_in | input | 1 | Observed vertical sync level; a high-to-low change is a falling edge |
| ser_clk | output | 1 | Serial clock to the device, idle low |
| ser_data | output | 1 | Serial data to the device, valid at `ser_clk` rising edges |
| ser_load_n | output | 1 | Active-low load strobe framing each write |
| vd_en | output | 1 | Vertical sync enable |
| hd_en | output | 1 | Horizontal sync enable |
| done | output | 1 | Sequence complete and output-control setting applied |

## Verification
Idle outputs are due at the first clock edge after `rst` is sampled. `done`, and the clearing of `done` and the enables on a restart, are due at the edge that samples `vd_in` low or `start` high. Inputs change on falling clock edges and these outputs are read at the next falling edge, exactly one register stage later. Serial content has no fixed cycle. A bench monitor rebuilds each frame from the values at every `ser_clk` rising edge, measures every clock phase in system cycles, and checks the sync enables at each bit. The bench then compares the frames with the table computed from the requirements once the enables rise. Sweeps cover several VD fall delays, VD toggling during the writes, VD held low at enable time, start requests during the writes, and resets at spread-out points of the sequence.

// File: rtl/imgfe_init_pkg.sv
package imgfe_init_pkg;

    localparam int CMD_ADDR_W = 6;
    localparam int CMD_DATA_W = 24;
    localparam int CMD_W      = CMD_ADDR_W + CMD_DATA_W;

    localparam logic [CMD_ADDR_W-1:0] REG_SOFT_RST = 6'h10;
    localparam logic [CMD_ADDR_W-1:0] REG_MODE     = 6'h00;
    localparam logic [CMD_ADDR_W-1:0] REG_CORE_RST = 6'h14;
    localparam logic [CMD_ADDR_W-1:0] REG_OUT_CTL  = 6'h11;

    // Packed so that the address occupies the low bits and leaves first.
    typedef struct packed {
        logic [CMD_DATA_W-1:0] data;
        logic [CMD_ADDR_W-1:0] addr;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_SHIFT,
        S_ADVANCE,
        S_WAIT_VD,
        S_DONE
    } seq_state_t;

    function automatic cmd_t cfg_entry(input int unsigned k,
                                       input int unsigned n_user,
                                       input logic [CMD_ADDR_W-1:0] base);
        cmd_t        c;
        int unsigned u;
        logic [7:0]  ub;
        u  = k - 1;
        ub = u[7:0];
        if (k == 0) begin
            c.addr = REG_SOFT_RST;
            c.data = 24'd1;
        end else if (k <= n_user) begin
            c.addr = base + u[CMD_ADDR_W-1:0];
            c.data = {8'(8'hA0 + ub), 8'(8'h3C ^ ub), 8'(ub * 8'd17 + 8'd1)};
        end else if (k == n_user + 1) begin
            c.addr = REG_MODE;
            c.data = 24'd0;
        end else if (k == n_user + 2) begin
            c.addr = REG_CORE_RST;
            c.data = 24'd1;
        end else begin
            c.addr = REG_OUT_CTL;
            c.data = 24'd1;
        end
        return c;
    endfunction

endpackage

// File: rtl/imgfe_cfg_rom.sv
module imgfe_cfg_rom
    import imgfe_init_pkg::*;
#(
    parameter int                    N_USER    = 4,
    parameter logic [CMD_ADDR_W-1:0] USER_BASE = 6'h20,
    localparam int                   N_ENT     = N_USER + 4,
    localparam int                   IDX_W     = $clog2(N_ENT)
) (
    input  logic [IDX_W-1:0] idx,
    output cmd_t             cmd
);

    cmd_t tbl [N_ENT];

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
        assign tbl[gi] = cfg_entry(gi, N_USER, USER_BASE);
    end

    always_comb begin
        cmd = '0;
        for (int k = 0; k < N_ENT; k++) begin
            if (int'(idx) == k) cmd = tbl[k];
        end
    end

endmodule

// File: rtl/imgfe_ser_shift.sv
module imgfe_ser_shift #(
    parameter int FRAME_W = 30,
    parameter int HALF    = 2,
    localparam int BIT_W  = $clog2(FRAME_W),
    localparam int DIV_W  = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [FRAME_W-1:0] word,
    output logic               ser_clk,
    output logic               ser_data,
    output logic               ser_load_n,
    output logic               frame_done
);

    logic [FRAME_W-1:0] sh;
    logic [BIT_W-1:0]   bit_cnt;
    logic [DIV_W-1:0]   div_cnt;
    logic               active;
    logic               sclk_q;
    logic               done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            bit_cnt <= '0;
            div_cnt <= '0;
            active  <= 1'b0;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (go) begin
                    sh      <= word;
                    active  <= 1'b1;
                    bit_cnt <= '0;
                    div_cnt <= '0;
                    sclk_q  <= 1'b0;
                end
            end else if (div_cnt == DIV_W'(HALF - 1)) begin
                div_cnt <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        sh      <= sh >> 1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign ser_clk    = sclk_q;
    assign ser_data   = active & sh[0];
    assign ser_load_n = ~active;
    assign frame_done = done_q;

    // R3: the serial clock only pulses inside a strobed frame
    p_clk_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> !ser_load_n);

    // R3: data does not move while the serial clock is high
    p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

endmodule

// File: rtl/imgfe_sync_edge.sv
module imgfe_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;

endmodule

// File: rtl/imgfe_init_seq.sv
module imgfe_init_seq
    import imgfe_init_pkg::*;
#(
    parameter int                    N_USER    = 4,
    parameter logic [CMD_ADDR_W-1:0] USER_BASE = 6'h20,
    parameter int                    SCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic vd_in,
    output logic ser_clk,
    output logic ser_data,
    output logic ser_load_n,
    output logic vd_en,
    output logic hd_en,
    output logic done
);

    localparam int               N_ENT = N_USER + 4;
    localparam int               IDX_W = $clog2(N_ENT);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(N_ENT - 1);

    seq_state_t       state, state_nx;
    logic [IDX_W-1:0] idx, idx_nx;
    cmd_t             cmd;
    logic             issue;
    logic             frame_done;
    logic             vd_fall;

    imgfe_cfg_rom #(.N_USER(N_USER), .USER_BASE(USER_BASE)) u_rom (
        .idx (idx),
        .cmd (cmd)
    );

    imgfe_ser_shift #(.FRAME_W(CMD_W), .HALF(SCLK_HALF)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .go         (issue),
        .word       (cmd),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_load_n (ser_load_n),
        .frame_done (frame_done)
    );

    imgfe_sync_edge u_vd_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (vd_in),
        .fall (vd_fall)
    );

    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    state_nx = S_ISSUE;
                    idx_nx   = '0;
                end
            end
            S_ISSUE: state_nx = S_SHIFT;
            S_SHIFT: begin
                if (frame_done) state_nx = S_ADVANCE;
            end
            S_ADVANCE: begin
                if (idx == LAST) begin
                    state_nx = S_WAIT_VD;
                end else begin
                    idx_nx   = idx + 1'b1;
                    state_nx = S_ISSUE;
                end
            end
            S_WAIT_VD: begin
                if (vd_fall) state_nx = S_DONE;
            end
            S_DONE: begin
                if (start) begin
                    state_nx = S_ISSUE;
                    idx_nx   = '0;
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    always_comb begin
        issue = 1'b0;
        vd_en = 1'b0;
        hd_en = 1'b0;
        done  = 1'b0;
        unique case (state)
            S_IDLE, S_SHIFT, S_ADVANCE: ;
            S_ISSUE:   issue = 1'b1;
            S_WAIT_VD: begin
                vd_en = 1'b1;
                hd_en = 1'b1;
            end
            S_DONE: begin
                vd_en = 1'b1;
                hd_en = 1'b1;
                done  = 1'b1;
            end
            default: ;
        endcase
    end

    // R9: no sync enable while a frame is strobed
    p_sync_off_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
        !ser_load_n |-> (!vd_en && !hd_en));

    // R10: done only rises on a VD falling edge seen by the edge detector
    p_done_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(vd_fall));

    // R11: a start during a frame leaves the table position alone
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (start && state == S_SHIFT) |=> (idx == $past(idx)));

    // R4: the first frame launched is the soft reset
    p_first_soft_rst_r4: assert property (@(posedge clk) disable iff (rst)
        (issue && idx == '0) |-> (cmd.addr == REG_SOFT_RST && cmd.data == 24'd1));

endmodule

// File: tb/imgfe_init_seq_bench.sv
module imgfe_init_seq_bench;

    localparam int N_USER = 4;
    localparam int HALF   = 2;
    localparam int N_ENT  = N_USER + 4;
    localparam int WD_LIM = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic vd_in = 1'b1;
    logic ser_clk, ser_data, ser_load_n, vd_en, hd_en, done;

    always #2.5 clk = ~clk;

    imgfe_init_seq #(.N_USER(N_USER), .USER_BASE(6'h20), .SCLK_HALF(HALF)) u_imgfe_init_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .vd_in      (vd_in),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_load_n (ser_load_n),
        .vd_en      (vd_en),
        .hd_en      (hd_en),
        .done       (done)
    );

    int nchk  = 0;
    int nfail = 0;

    // ---------------- serial monitor ----------------
    logic        mon_clr = 1'b1;
    logic [29:0] m_sh;
    logic [5:0]  cap_a [16];
    logic [23:0] cap_d [16];
    int nfr, m_bits, bad_len, clk_out, tim_err, sync_viol, hi_len, lo_len;
    logic p_sclk, p_load;

    always @(negedge clk) begin
        if (mon_clr) begin
            nfr = 0; m_bits = 0; bad_len = 0; clk_out = 0; tim_err = 0;
            sync_viol = 0; hi_len = 0; lo_len = 0; m_sh = '0;
            p_sclk = 1'b0; p_load = 1'b1;
        end else begin
            if (!ser_load_n && p_load) begin
                m_bits = 0;
                lo_len = 0;
            end
            if (ser_clk && !p_sclk) begin
                if (ser_load_n) clk_out++;
                if (vd_en || hd_en) sync_viol++;
                if (lo_len != HALF) tim_err++;
                m_sh = {ser_data, m_sh[29:1]};
                m_bits++;
                hi_len = 1;
            end else if (!ser_clk && p_sclk) begin
                if (hi_len != HALF) tim_err++;
                lo_len = ser_load_n ? 0 : 1;
            end else if (ser_clk) begin
                hi_len++;
            end else if (!ser_load_n) begin
                lo_len++;
            end
            if (ser_load_n && !p_load) begin
                if (m_bits == 30 && nfr < 16) begin
                    cap_a[nfr] = m_sh[5:0];
                    cap_d[nfr] = m_sh[29:6];
                    nfr++;
                end else begin
                    bad_len++;
                end
            end
            p_sclk = ser_clk;
            p_load = ser_load_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_addr(input int k);
        if (k == 0)               return 6'h10;
        else if (k <= N_USER)     return 6'(32 + k - 1);
        else if (k == N_USER + 1) return 6'h00;
        else if (k == N_USER + 2) return 6'h14;
        else                      return 6'h11;
    endfunction

    function automatic logic [23:0] exp_data(input int k);
        int i;
        i = k - 1;
        if (k == 0)               return 24'd1;
        else if (k <= N_USER)     return {8'((160 + i) % 256), 8'(60 ^ i), 8'((17 * i + 1) % 256)};
        else if (k == N_USER + 1) return 24'd0;
        else                      return 24'd1;
    endfunction

    function automatic string req_of(input int k);
        if (k == 0)               return "R4";
        else if (k <= N_USER)     return "R5";
        else if (k == N_USER + 1) return "R6";
        else if (k == N_USER + 2) return "R7";
        else                      return "R8";
    endfunction

    task automatic clear_mon();
        mon_clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        chk("R1", {tag, " ser_load_n"}, ser_load_n, 1);
        chk("R1", {tag, " ser_clk"},    ser_clk, 0);
        chk("R1", {tag, " ser_data"},   ser_data, 0);
        chk("R1", {tag, " vd_en"},      vd_en, 0);
        chk("R1", {tag, " hd_en"},      hd_en, 0);
        chk("R1", {tag, " done"},       done, 0);
    endtask

    task automatic check_seq();
        int n10;
        n10 = 0;
        chk("R2", "frame count", nfr, N_ENT);
        chk("R3", "frames of wrong length", bad_len, 0);
        chk("R3", "clock edges outside strobe", clk_out, 0);
        chk("R3", "clock phase length errors", tim_err, 0);
        chk("R9", "sync enabled at a bit", sync_viol, 0);
        for (int k = 0; k < N_ENT && k < nfr; k++) begin
            chk(req_of(k), $sformatf("frame %0d addr", k), cap_a[k], exp_addr(k));
            chk(req_of(k), $sformatf("frame %0d data", k), cap_d[k], exp_data(k));
            if (k > 0 && cap_a[k] == 6'h10) n10++;
        end
        chk("R4", "later writes to soft reset", n10, 0);
    endtask

    // mode 0: VD high; mode 1: VD toggles during writes then is held low
    task automatic wait_enables(input int mode);
        int n;
        n = 0;
        while (!vd_en && n < 5000) begin
            if (mode == 1) vd_in = (nfr >= N_ENT - 2) ? 1'b0 : n[3];
            chk("R10", "done before enables", done, 0);
            @(negedge clk);
            n++;
        end
        chk("R9", "enables raised after last frame", vd_en, 1);
        chk("R9", "hd enable raised", hd_en, 1);
    endtask

    task automatic finish_vd(input int dly);
        for (int j = 0; j < dly; j++) begin
            @(negedge clk);
            chk("R10", "done waits for VD fall", done, 0);
        end
        vd_in = 1'b0;
        @(negedge clk);
        chk("R10", "done after VD fall", done, 1);
        vd_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "done holds", done, 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WD_LIM) @(posedge clk);
        $display("FAIL R2 watchdog: cycles %0d expected below %0d", WD_LIM, WD_LIM);
        $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        repeat (4) @(negedge clk);
        check_idle("after power-on reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("idle without start");

        // R2..R10: full runs with VD fall delays 0..5
        for (int d = 0; d < 6; d++) begin
            clear_mon();
            vd_in = 1'b1;
            pulse_start();
            wait_enables(0);
            check_seq();
            finish_vd(d);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            check_idle("reset from done");
        end

        // R10: VD toggling during writes, low when enables rise
        clear_mon();
        pulse_start();
        wait_enables(1);
        check_seq();
        vd_in = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R10", "low VD at enable is no edge", done, 0);
        end
        vd_in = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk("R10", "VD rise is no edge", done, 0);
        end
        finish_vd(0);

        // R12: restart from done
        clear_mon();
        pulse_start();
        chk("R12", "done cleared on restart", done, 0);
        chk("R12", "vd_en cleared on restart", vd_en, 0);
        chk("R12", "hd_en cleared on restart", hd_en, 0);
        wait_enables(0);
        check_seq();
        finish_vd(2);

        // R11: start requests in the middle of the writes
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        clear_mon();
        pulse_start();
        repeat (300) @(negedge clk);
        pulse_start();
        repeat (250) @(negedge clk);
        pulse_start();
        wait_enables(0);
        chk("R11", "frames with start during writes", nfr, N_ENT);
        check_seq();
        finish_vd(1);

        // R1: reset swept across the sequence
        for (int off = 3; off < 1000; off += 111) begin
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            pulse_start();
            repeat (off) @(negedge clk);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            check_idle($sformatf("reset at offset %0d", off));
            repeat (5) @(negedge clk);
            chk("R1", "stays idle after reset", ser_load_n, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule